// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides whether a received Ethernet frame should be kept, using only the frame's 48-bit destination address. The address arrives one byte per cycle. A start strobe marks the first byte. As the bytes arrive, the block computes a running CRC-32 over them and also assembles the full address. After the last address byte, it produces a single registered verdict: accept or reject, a hash-hit flag, and the 6-bit hash index taken from the CRC.

Five enable bits choose which classes of address are kept:
- exact match against a programmed station address,
- unicast addresses that hit the hash table,
- multicast addresses that hit the hash table,
- the broadcast address,
- everything (promiscuous).

The enabled classes are combined with OR. The promiscuous bit overrides all the others.

The filter settings are copied into internal shadow registers only while the receive-enable input is low. Software can therefore rewrite the station address, the table or the enables at any time. A change takes effect only after reception has been paused for at least one cycle.

Top module: `eth_da_filter`

## Requirements
- R1: One cycle after the sixth accepted address byte, `res_valid` rises and the result outputs take their new values. They then hold unchanged until the next accepted start strobe. The cycle after an accepted start strobe, `res_valid` is low.
- R2: When mode bit 4 (promiscuous) is set, every completed address is accepted, whatever the other enables are.
- R3: When mode bit 0 (exact) is set, an address equal to the station address is accepted. The first received byte is compared with station bits [7:0], and the sixth with bits [47:40].
- R4: When mode bit 3 (broadcast) is set, the all-ones address is accepted.
- R5: The hash index equals bits [31:26] of a CRC-32. The CRC uses polynomial 0x04C11DB7 and starts from all ones. It shifts its most significant bit out first and takes each byte least-significant bit first, with no final inversion.
- R6: `res_hashed` equals the hash-table bit selected by the hash index, for every completed address.
- R7: When mode bit 1 (unicast hash) is set, an address is accepted if address bit 0 (bit 0 of the first byte) is 0 and the selected table bit is 1.
- R8: When mode bit 2 (multicast hash) is set, an address is accepted if address bit 0 is 1 and the selected table bit is 1.
- R9: Enabled classes combine with OR. With all five mode bits clear, every address is rejected.
- R10: `res_hash_ok` is high only when an enabled hash class (R7 or R8) accepted the address. `res_hash_idx` shows the index then and reads zero otherwise.
- R11: Configuration inputs are sampled only on cycles with `rx_enable` low. Changes made while it is high have no effect on results.
- R12: Address bytes presented while `rx_enable` is low are ignored. The result outputs keep their values.
- R13: Reset clears all result outputs and the sampled configuration, which leaves every mode disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_enable | input | 1 | Reception enable; configuration is sampled while low |
| cfg_mode | input | 5 | Enables: bit0 exact, bit1 unicast hash, bit2 multicast hash, bit3 broadcast, bit4 promiscuous |
| cfg_station | input | 48 | Station address, first byte in bits [7:0] |
| cfg_table | input | 64 | Hash table, bit n selects index n |
| da_valid | input | 1 | Address byte valid |
| da_start | input | 1 | Marks the first address byte (with `da_valid`) |
| da_byte | input | 8 | Address byte |
| res_valid | output | 1 | Result valid |
| res_accept | output | 1 | Frame accepted |
| res_hashed | output | 1 | Selected hash-table bit was set |
| res_hash_ok | output | 1 | Accepted through a hash class |
| res_hash_idx | output | 6 | Hash index, zero unless `res_hash_ok` |

## Verification
The bench builds the block with its default parameters: six address bytes and a 6-bit hash index, which gives a 64-entry table. Random addresses and random 64-bit tables make each table entry reachable in both unicast and multicast form, so the CRC bit order and the decoder are both exercised. Directed cases cover the following:
- the exact station match and a one-bit miss,
- the all-ones address and a near miss,
- the empty mode set,
- promiscuous override,
- configuration changed while reception is enabled,
- bytes sent while reception is disabled.

// File: rtl/dafilt_pkg.sv
package dafilt_pkg;

    localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

    typedef struct packed {
        logic promisc;
        logic bcast;
        logic mc_hash;
        logic uc_hash;
        logic exact;
    } mode_t;

    typedef struct packed {
        logic accept;
        logic hashed;
        logic hash_ok;
    } verdict_t;

    function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[31] ^ d[i]) r = (r << 1) ^ CRC_POLY;
            else              r = r << 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/dafilt_cfg.sv
module dafilt_cfg
    import dafilt_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int TBL_W  = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_enable,
    input  mode_t             mode_in,
    input  logic [ADDR_W-1:0] station_in,
    input  logic [TBL_W-1:0]  table_in,
    output mode_t             mode_q,
    output logic [ADDR_W-1:0] station_q,
    output logic [TBL_W-1:0]  table_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= '0;
            station_q <= '0;
            table_q   <= '0;
        end else if (!rx_enable) begin
            mode_q    <= mode_in;
            station_q <= station_in;
            table_q   <= table_in;
        end
    end

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        rx_enable |=> ($stable(mode_q) && $stable(station_q) && $stable(table_q))); // R11

endmodule

// File: rtl/dafilt_capture.sv
module dafilt_capture
    import dafilt_pkg::*;
#(
    parameter int ADDR_BYTES = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    rx_enable,
    input  logic                    da_valid,
    input  logic                    da_start,
    input  logic [7:0]              da_byte,
    output logic                    frame_start,
    output logic                    complete,
    output logic [ADDR_BYTES*8-1:0] da_full,
    output logic [31:0]             crc_full
);

    localparam int CNT_W = $clog2(ADDR_BYTES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ADDR_BYTES - 1);
    localparam logic [CNT_W-1:0] DONE = CNT_W'(ADDR_BYTES);

    logic [CNT_W-1:0]                cnt_q;
    logic [ADDR_BYTES-1:0][7:0]      da_q;
    logic [ADDR_BYTES-1:0][7:0]      da_n;
    logic [31:0]                     crc_q;
    logic [31:0]                     crc_base;
    logic                            take;
    logic                            in_frame;
    logic [CNT_W-1:0]                slot;

    assign take        = da_valid && rx_enable;
    assign frame_start = take && da_start;
    assign in_frame    = take && !da_start && (cnt_q != '0) && (cnt_q < DONE);
    assign slot        = frame_start ? '0 : cnt_q;
    assign crc_base    = frame_start ? CRC_SEED : crc_q;
    assign crc_full    = crc_byte(crc_base, da_byte);

    always_comb begin
        da_n = da_q;
        if (slot < DONE) da_n[slot] = da_byte;
    end

    assign da_full  = da_n;
    assign complete = (frame_start && (ADDR_BYTES == 1)) || (in_frame && (cnt_q == LAST));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            crc_q <= CRC_SEED;
            da_q  <= '0;
        end else if (frame_start || in_frame) begin
            cnt_q <= slot + 1'b1;
            crc_q <= crc_full;
            da_q  <= da_n;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= DONE); // R1
    AST_IGNORE_DISABLED: assert property (@(posedge clk) disable iff (rst)
        !rx_enable |=> ($stable(cnt_q) && $stable(crc_q) && $stable(da_q))); // R12

endmodule

// File: rtl/dafilt_decide.sv
module dafilt_decide
    import dafilt_pkg::*;
#(
    parameter int ADDR_W    = 48,
    parameter int HASH_BITS = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 frame_start,
    input  logic                 complete,
    input  logic [ADDR_W-1:0]    da,
    input  logic [31:0]          crc,
    input  mode_t                mode,
    input  logic [ADDR_W-1:0]    station,
    input  logic [(1<<HASH_BITS)-1:0] hash_table,
    output logic                 res_valid,
    output verdict_t             res,
    output logic [HASH_BITS-1:0] res_idx
);

    localparam int TBL_W = 1 << HASH_BITS;

    logic [HASH_BITS-1:0] idx;
    logic [TBL_W-1:0]     onehot;
    logic                 tbl_hit;
    logic                 is_group;
    logic                 is_bcast;
    logic                 is_self;
    logic                 hash_take;
    verdict_t             v;

    assign idx = crc[31 -: HASH_BITS];

    for (genvar g = 0; g < TBL_W; g++) begin : g_dec
        assign onehot[g] = (idx == HASH_BITS'(g));
    end

    assign tbl_hit   = |(onehot & hash_table);
    assign is_group  = da[0];
    assign is_bcast  = &da;
    assign is_self   = (da == station);
    assign hash_take = tbl_hit && ((mode.uc_hash && !is_group) || (mode.mc_hash && is_group));

    always_comb begin
        v.hashed  = tbl_hit;
        v.hash_ok = hash_take;
        v.accept  = mode.promisc
                 || (mode.exact && is_self)
                 || (mode.bcast && is_bcast)
                 || hash_take;
    end

    always_ff @(posedge clk) begin
        if (rst || frame_start) begin
            res_valid <= 1'b0;
            res       <= '0;
            res_idx   <= '0;
        end else if (complete) begin
            res_valid <= 1'b1;
            res       <= v;
            res_idx   <= hash_take ? idx : '0;
        end
    end

    AST_PROMISC_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (complete && mode.promisc) |=> (res_valid && res.accept)); // R2
    AST_NONE_REJECTS: assert property (@(posedge clk) disable iff (rst)
        (complete && mode == '0) |=> !res.accept); // R9
    AST_OK_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        res.hash_ok |-> (res.accept && res.hashed)); // R10
    AST_IDX_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !res.hash_ok |-> (res_idx == '0)); // R10
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !frame_start) |=> (res_valid && $stable(res) && $stable(res_idx))); // R1

endmodule

// File: rtl/eth_da_filter.sv
module eth_da_filter
    import dafilt_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int HASH_BITS  = 6
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         rx_enable,
    input  logic [4:0]                   cfg_mode,
    input  logic [ADDR_BYTES*8-1:0]      cfg_station,
    input  logic [(1<<HASH_BITS)-1:0]    cfg_table,
    input  logic                         da_valid,
    input  logic                         da_start,
    input  logic [7:0]                   da_byte,
    output logic                         res_valid,
    output logic                         res_accept,
    output logic                         res_hashed,
    output logic                         res_hash_ok,
    output logic [HASH_BITS-1:0]         res_hash_idx
);

    localparam int ADDR_W = ADDR_BYTES * 8;
    localparam int TBL_W  = 1 << HASH_BITS;

    mode_t             mode_q;
    logic [ADDR_W-1:0] station_q;
    logic [TBL_W-1:0]  table_q;
    logic              frame_start;
    logic              complete;
    logic [ADDR_W-1:0] da_full;
    logic [31:0]       crc_full;
    verdict_t          verdict;

    dafilt_cfg #(.ADDR_W(ADDR_W), .TBL_W(TBL_W)) cfg_i (
        .clk        (clk),
        .rst        (rst),
        .rx_enable  (rx_enable),
        .mode_in    (mode_t'(cfg_mode)),
        .station_in (cfg_station),
        .table_in   (cfg_table),
        .mode_q     (mode_q),
        .station_q  (station_q),
        .table_q    (table_q)
    );

    dafilt_capture #(.ADDR_BYTES(ADDR_BYTES)) cap_i (
        .clk         (clk),
        .rst         (rst),
        .rx_enable   (rx_enable),
        .da_valid    (da_valid),
        .da_start    (da_start),
        .da_byte     (da_byte),
        .frame_start (frame_start),
        .complete    (complete),
        .da_full     (da_full),
        .crc_full    (crc_full)
    );

    dafilt_decide #(.ADDR_W(ADDR_W), .HASH_BITS(HASH_BITS)) dec_i (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .complete    (complete),
        .da          (da_full),
        .crc         (crc_full),
        .mode        (mode_q),
        .station     (station_q),
        .hash_table  (table_q),
        .res_valid   (res_valid),
        .res         (verdict),
        .res_idx     (res_hash_idx)
    );

    assign res_accept  = verdict.accept;
    assign res_hashed  = verdict.hashed;
    assign res_hash_ok = verdict.hash_ok;

endmodule

// File: tb/eth_da_filter_tb_top.sv
module eth_da_filter_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_enable = 1'b0;
    logic [4:0]  cfg_mode = '0;
    logic [47:0] cfg_station = '0;
    logic [63:0] cfg_table = '0;
    logic        da_valid = 1'b0;
    logic        da_start = 1'b0;
    logic [7:0]  da_byte = '0;
    logic        res_valid, res_accept, res_hashed, res_hash_ok;
    logic [5:0]  res_hash_idx;

    int n_checks = 0;
    int n_fails  = 0;

    logic [4:0]  a_mode;
    logic [47:0] a_sta;
    logic [63:0] a_tbl;

    always #5 clk = ~clk;

    eth_da_filter dut_i (
        .clk(clk), .rst(rst), .rx_enable(rx_enable),
        .cfg_mode(cfg_mode), .cfg_station(cfg_station), .cfg_table(cfg_table),
        .da_valid(da_valid), .da_start(da_start), .da_byte(da_byte),
        .res_valid(res_valid), .res_accept(res_accept), .res_hashed(res_hashed),
        .res_hash_ok(res_hash_ok), .res_hash_idx(res_hash_idx)
    );

    function automatic logic [5:0] ref_idx(input logic [47:0] da);
        logic [31:0] c;
        c = 32'hFFFFFFFF;
        for (int i = 0; i < 48; i++) begin
            logic fb;
            fb = c[31] ^ da[i];
            c = {c[30:0], 1'b0};
            if (fb) c = c ^ 32'h04C11DB7;
        end
        return c[31:26];
    endfunction

    // {valid, accept, hashed, hash_ok, idx}
    function automatic logic [9:0] ref_out(input logic [47:0] da, input logic [4:0] m,
                                           input logic [47:0] sta, input logic [63:0] tbl);
        logic [5:0] ix;
        logic hit, hok, acc;
        ix  = ref_idx(da);
        hit = tbl[ix];
        hok = hit && ((m[1] && !da[0]) || (m[2] && da[0]));
        acc = m[4] || (m[0] && da == sta) || (m[3] && da == '1) || hok;
        return {1'b1, acc, hit, hok, hok ? ix : 6'd0};
    endfunction

    function automatic logic [9:0] outs();
        return {res_valid, res_accept, res_hashed, res_hash_ok, res_hash_idx};
    endfunction

    task automatic chk(input string tag, input logic [9:0] act, input logic [9:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic configure(input logic [4:0] m, input logic [47:0] s, input logic [63:0] t);
        @(negedge clk);
        rx_enable = 1'b0;
        cfg_mode = m; cfg_station = s; cfg_table = t;
        a_mode = m; a_sta = s; a_tbl = t;
        @(negedge clk);
        rx_enable = 1'b1;
    endtask

    task automatic send_da(input logic [47:0] da);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (i == 1 && rx_enable) chk("R1 valid cleared after start", {9'd0, res_valid}, 10'd0);
            da_valid = 1'b1;
            da_start = (i == 0);
            da_byte  = da[i*8 +: 8];
        end
        @(negedge clk);
        da_valid = 1'b0;
        da_start = 1'b0;
    endtask

    task automatic frame(input string tag, input logic [47:0] da);
        send_da(da);
        chk(tag, outs(), ref_out(da, a_mode, a_sta, a_tbl));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [47:0] da;
        logic [9:0]  held;
        void'($urandom(32'd20240607));
        a_mode = '0; a_sta = '0; a_tbl = '0;

        // R13: reset state; hold rx_enable high with promiscuous inputs
        rx_enable = 1'b1;
        cfg_mode = 5'h1F; cfg_station = 48'h1; cfg_table = '1;
        repeat (3) @(negedge clk);
        chk("R13 reset outputs", outs(), 10'd0);
        rst = 1'b0;
        frame("R13 sampled config cleared", 48'h0000_0000_00FF);

        // R2 promiscuous
        configure(5'b10000, 48'h123456789ABC, 64'd0);
        frame("R2 promiscuous random", 48'hA5A5_1234_5679);
        frame("R2 promiscuous unicast", 48'h0102_0304_0506);

        // R3 exact match, byte order
        configure(5'b00001, 48'h665544332210, 64'd0);
        frame("R3 exact hit", 48'h665544332210);
        frame("R3 exact miss last byte", 48'h675544332210);
        frame("R3 exact miss first byte", 48'h665544332211);

        // R4 broadcast
        configure(5'b01000, 48'h0, 64'd0);
        frame("R4 broadcast hit", 48'hFFFF_FFFF_FFFF);
        frame("R4 broadcast near miss", 48'h7FFF_FFFF_FFFF);

        // R9 nothing enabled
        configure(5'b00000, 48'hFFFF_FFFF_FFFF, '1);
        frame("R9 empty mode rejects", 48'hFFFF_FFFF_FFFF);

        // R7 unicast hash, R8 multicast hash, R5/R6 index
        configure(5'b00010, 48'h0, '1);
        frame("R7 unicast hash even", 48'h0000_1122_3344);
        frame("R7 unicast hash odd rejected", 48'h0000_1122_3345);
        configure(5'b00100, 48'h0, '1);
        frame("R8 multicast hash odd", 48'h0000_0000_5E01);
        frame("R8 multicast hash even rejected", 48'h0000_0000_5E00);
        da = 48'h0000_0000_5E01;
        configure(5'b00100, 48'h0, ~(64'd1 << ref_idx(da)));
        frame("R6 table bit clear", da);
        configure(5'b00100, 48'h0, 64'd1 << ref_idx(da));
        frame("R5 index single table bit", da);

        // R11 config change while enabled has no effect
        configure(5'b00001, 48'h00000000AB00, 64'd0);
        @(negedge clk);
        cfg_mode = 5'h1F; cfg_table = '1;
        frame("R11 change while enabled ignored", 48'h1234_5678_9ABD);
        @(negedge clk);
        cfg_mode = a_mode; cfg_table = a_tbl;
        frame("R11 exact still active", 48'h00000000AB00);

        // R12 bytes ignored while disabled
        held = outs();
        @(negedge clk);
        rx_enable = 1'b0;
        send_da(48'hFFFF_FFFF_FFFF);
        chk("R12 disabled bytes ignored", outs(), held);
        @(negedge clk);
        rx_enable = 1'b1;

        // R1 hold: extra bytes and idle time do not change the result
        frame("R1 result", 48'h00000000AB00);
        held = outs();
        @(negedge clk);
        da_valid = 1'b1; da_byte = 8'h77;
        @(negedge clk);
        da_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 result held", outs(), held);

        // Random mix (R2-R10)
        for (int n = 0; n < 240; n++) begin
            if (n % 8 == 0) begin
                logic [4:0] m;
                m = 5'($urandom) & 5'h0F;
                if ($urandom % 8 == 0) m[4] = 1'b1;
                configure(m, {16'($urandom), 32'($urandom)}, {32'($urandom), 32'($urandom)});
            end
            case ($urandom % 4)
                0: da = {16'($urandom), 32'($urandom)};
                1: da = a_sta;
                2: da = '1;
                default: da = {16'($urandom), 32'($urandom)} ^ 48'h1;
            endcase
            frame("R10 random mix", da);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule